// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block runs once after power-on reset and copies a program image out of a serial flash into an asynchronous 16-bit SRAM. It then switches instruction fetch over to that SRAM. It works through an external SPI byte engine with a request/busy handshake. First it wakes the flash and waits out the flash's wake-up time. Next it opens one read transaction at a fixed flash address and collects the returned bytes into 16-bit words. It writes each word to the next SRAM location and, at the end, sends the flash back to its deep sleep state.

After the final command byte, a sticky `go` flag rises. From then on the SRAM address pins follow the CPU program counter, and the instruction word is taken from the SRAM read data instead of the ROM. The CPU is held in reset for the whole load. It leaves reset one cycle after `go` rises, so it starts at address 0 running from SRAM. The `spi_frame` output tells the byte engine to keep the flash selected between bytes. When `spi_frame` is low and the engine is idle, chip select is released.

Top module: `flash_boot_loader`

## Requirements
- R1: The first SPI byte after reset is the wake-up command 0xAB, sent with `spi_frame` low so that chip select is released after it.
- R2: At least `WAKE_CYCLES` clock cycles separate the end of the wake-up byte (busy falling) from the next request.
- R3: The read transaction sends 0x03, then the three bytes of `FLASH_ADDR` most significant first (0x01, 0x00, 0x00 by default), then 2*`WORDS` dummy bytes. `spi_frame` is high for every byte of this transaction.
- R4: Received bytes are paired with the first byte in bits 15:8 and the second in bits 7:0. Exactly `WORDS` words are written, to SRAM addresses 0, 1, 2 … in order.
- R5: After the last data byte, the final SPI byte is the sleep command 0xB9, sent with `spi_frame` low. `go` rises only after that byte completes.
- R6: `sram_ce_n` is always 0. In a write cycle `sram_we_n`=0, `sram_oe_n`=1 and `sram_dq_oe`=1, with `sram_dq_o` holding a registered word. In every other cycle `sram_we_n`=1, `sram_oe_n`=0 and `sram_dq_oe`=0 (bus released).
- R7: Once set, `go` stays set until `rst`. `cpu_rst` is 1 whenever `go` is 0, and it falls exactly one cycle after `go` rises.
- R8: While `go`=0, `instr` equals `rom_data`. While `go`=1, `sram_addr` equals `cpu_pc` and `instr` equals `sram_dq_i`.
- R9: `spi_req` is a one-cycle pulse and is never raised while `spi_busy` is high. The engine must raise busy in the cycle after it samples a request, and the received byte is taken only once busy is low again.
- R10: During and right after reset: `go`=0, `cpu_rst`=1, `spi_req`=0, `sram_we_n`=1, `sram_oe_n`=0, `sram_dq_oe`=0.
- R11: After `go`, no further SPI request or SRAM write occurs, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| spi_req | output | 1 | One-cycle start strobe for one byte transfer |
| spi_tx | output | 8 | Byte to shift out |
| spi_frame | output | 1 | Keep flash selected after this byte |
| spi_busy | input | 1 | Byte engine busy |
| spi_rx | input | 8 | Byte received by the last transfer |
| sram_addr | output | AW | SRAM address |
| sram_dq_o | output | 16 | SRAM write data |
| sram_dq_oe | output | 1 | Drive the SRAM data bus |
| sram_dq_i | input | 16 | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| cpu_pc | input | AW | CPU program counter |
| rom_data | input | 16 | Instruction word from ROM |
| instr | output | 16 | Instruction word to the CPU |
| cpu_rst | output | 1 | CPU reset |
| go | output | 1 | Sticky load-complete flag |

## Verification
The embedded assertions check the following on every cycle: the request is a single-cycle pulse and never overlaps busy, each assembled word appears on the SRAM bus one cycle after it forms with its low byte taken from the latest received byte, `go` never drops and follows the sequencer's final step, and `cpu_rst` tracks `go` one cycle later. Only the bench scenarios can show the whole command stream: its byte values and their order, the frame level on each byte, the wake-up gap, the SRAM image contents against the flash data, and the fetch-source switch under a changing program counter. Two loads with different flash images separated by a reset show that reset re-arms the sequence.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_DUMMY = 8'h00;

  typedef enum logic [2:0] {
    ST_WAKE, ST_PAUSE, ST_CMD, ST_DATA, ST_SLEEP, ST_DONE
  } step_t;

  typedef enum logic [1:0] {
    PH_ISSUE, PH_GAP, PH_WAIT
  } phase_t;
endpackage

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int          WORDS       = 6,
  parameter int          WAKE_CYCLES = 75,
  parameter logic [23:0] FLASH_ADDR  = 24'h010000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_busy,
  input  logic [7:0] spi_rx,
  output logic       spi_req,
  output logic [7:0] spi_tx,
  output logic       spi_frame,
  output logic       byte_valid,
  output logic [7:0] byte_out,
  output logic       go_set
);
  import boot_pkg::*;
  localparam int BYTE_TOTAL = 2 * WORDS;
  localparam int BC_W = (BYTE_TOTAL > 1) ? $clog2(BYTE_TOTAL) : 1;
  localparam int DC_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;

  step_t             step;
  phase_t            phase;
  logic [1:0]        idx;
  logic [BC_W-1:0]   bcnt;
  logic [DC_W-1:0]   dcnt;
  logic [7:0]        next_byte;

  always_comb begin
    unique case (step)
      ST_WAKE:  next_byte = OP_WAKE;
      ST_CMD: begin
        unique case (idx)
          2'd0:    next_byte = OP_READ;
          2'd1:    next_byte = FLASH_ADDR[23:16];
          2'd2:    next_byte = FLASH_ADDR[15:8];
          default: next_byte = FLASH_ADDR[7:0];
        endcase
      end
      ST_SLEEP: next_byte = OP_SLEEP;
      default:  next_byte = OP_DUMMY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= ST_WAKE;
      phase      <= PH_ISSUE;
      idx        <= '0;
      bcnt       <= '0;
      dcnt       <= '0;
      spi_req    <= 1'b0;
      spi_tx     <= '0;
      spi_frame  <= 1'b0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
      go_set     <= 1'b0;
    end else begin
      spi_req    <= 1'b0;
      byte_valid <= 1'b0;
      go_set     <= 1'b0;
      case (step)
        ST_PAUSE: begin
          if (dcnt == DC_W'(WAKE_CYCLES - 1)) begin
            step  <= ST_CMD;
            phase <= PH_ISSUE;
            idx   <= '0;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_DONE: ;
        default: begin
          case (phase)
            PH_ISSUE: begin
              spi_req   <= 1'b1;
              spi_tx    <= next_byte;
              spi_frame <= (step == ST_CMD) || (step == ST_DATA);
              phase     <= PH_GAP;
            end
            PH_GAP: phase <= PH_WAIT;
            default: begin
              if (!spi_busy) begin
                phase <= PH_ISSUE;
                case (step)
                  ST_WAKE: begin
                    step <= ST_PAUSE;
                    dcnt <= '0;
                  end
                  ST_CMD: begin
                    if (idx == 2'd3) begin
                      step <= ST_DATA;
                      bcnt <= '0;
                    end else begin
                      idx <= idx + 1'b1;
                    end
                  end
                  ST_DATA: begin
                    byte_valid <= 1'b1;
                    byte_out   <= spi_rx;
                    if (bcnt == BC_W'(BYTE_TOTAL - 1)) begin
                      step      <= ST_SLEEP;
                      spi_frame <= 1'b0;
                    end else begin
                      bcnt <= bcnt + 1'b1;
                    end
                  end
                  default: begin
                    step   <= ST_DONE;
                    go_set <= 1'b1;
                  end
                endcase
              end
            end
          endcase
        end
      endcase
    end
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    spi_req |=> !spi_req) else $error("request longer than one cycle");
  assert_req_idle_R9: assert property (@(posedge clk) disable iff (rst)
    spi_req |-> !spi_busy) else $error("request while busy");
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DONE) |-> !spi_req) else $error("request after done");
endmodule

// File: rtl/word_pack.sv
module word_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output logic        word_valid,
  output logic [15:0] word
);
  logic       second;
  logic [7:0] hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      second     <= 1'b0;
      hi         <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (byte_valid) begin
        if (!second) begin
          hi     <= byte_in;
          second <= 1'b1;
        end else begin
          word       <= {hi, byte_in};
          word_valid <= 1'b1;
          second     <= 1'b0;
        end
      end
    end
  end

  assert_low_byte_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word[7:0] == $past(byte_in))) else $error("low byte mismatch");
  assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid) else $error("back-to-back words");
endmodule

// File: rtl/sram_port.sv
module sram_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_valid,
  input  logic [15:0]   word,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   dq_o,
  output logic          dq_oe,
  output logic          oe_n,
  output logic          we_n
);
  logic          wr_act;
  logic [AW-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act    <= 1'b0;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      oe_n      <= 1'b0;
      we_n      <= 1'b1;
      wr_addr   <= '0;
      next_addr <= '0;
    end else begin
      wr_act <= word_valid;
      dq_oe  <= word_valid;
      oe_n   <= word_valid;
      we_n   <= !word_valid;
      if (word_valid) begin
        dq_o    <= word;
        wr_addr <= next_addr;
      end
      if (wr_act) next_addr <= next_addr + 1'b1;
    end
  end

  assert_strobe_follow_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> (!we_n && oe_n && dq_oe)) else $error("write strobes late");
  assert_data_held_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> (dq_o == $past(word))) else $error("write data mismatch");
  assert_bus_free_R6: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> (we_n && !dq_oe)) else $error("stray write");
endmodule

// File: rtl/fetch_mux.sv
module fetch_mux #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_set,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] cpu_pc,
  input  logic [15:0]   rom_data,
  input  logic [15:0]   sram_dq_i,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   instr,
  output logic          cpu_rst,
  output logic          go
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go      <= 1'b0;
      cpu_rst <= 1'b1;
    end else begin
      if (go_set) go <= 1'b1;
      cpu_rst <= !go;
    end
  end

  assign sram_addr = go ? cpu_pc    : wr_addr;
  assign instr     = go ? sram_dq_i : rom_data;

  assert_go_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    go |=> go) else $error("go dropped");
  assert_go_from_seq_R7: assert property (@(posedge clk) disable iff (rst)
    go_set |=> go) else $error("go not set");
  assert_rst_release_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(go) |-> cpu_rst) else $error("cpu reset released early");
  assert_rst_low_R7: assert property (@(posedge clk) disable iff (rst)
    go |=> !cpu_rst) else $error("cpu reset stuck");
endmodule

// File: rtl/flash_boot_loader.sv
module flash_boot_loader #(
  parameter int          WORDS       = 6,
  parameter int          WAKE_CYCLES = 75,
  parameter logic [23:0] FLASH_ADDR  = 24'h010000,
  parameter int          AW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          spi_req,
  output logic [7:0]    spi_tx,
  output logic          spi_frame,
  input  logic          spi_busy,
  input  logic [7:0]    spi_rx,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [15:0]   sram_dq_i,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  input  logic [AW-1:0] cpu_pc,
  input  logic [15:0]   rom_data,
  output logic [15:0]   instr,
  output logic          cpu_rst,
  output logic          go
);
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          word_valid;
  logic [15:0]   word;
  logic          go_set;
  logic [AW-1:0] wr_addr;

  assign sram_ce_n = 1'b0;

  boot_seq #(.WORDS(WORDS), .WAKE_CYCLES(WAKE_CYCLES), .FLASH_ADDR(FLASH_ADDR)) u_seq (
    .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_rx(spi_rx),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_frame(spi_frame),
    .byte_valid(byte_valid), .byte_out(byte_data), .go_set(go_set));

  word_pack u_pack (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_data),
    .word_valid(word_valid), .word(word));

  sram_port #(.AW(AW)) u_sram (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word(word),
    .wr_addr(wr_addr), .dq_o(sram_dq_o), .dq_oe(sram_dq_oe),
    .oe_n(sram_oe_n), .we_n(sram_we_n));

  fetch_mux #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .go_set(go_set), .wr_addr(wr_addr),
    .cpu_pc(cpu_pc), .rom_data(rom_data), .sram_dq_i(sram_dq_i),
    .sram_addr(sram_addr), .instr(instr), .cpu_rst(cpu_rst), .go(go));

  assert_go_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    go |-> (sram_we_n && !spi_req)) else $error("activity after go");
endmodule

// File: tb/tb_flash_boot_loader.sv
`timescale 1ns/1ps
module tb_flash_boot_loader;
  localparam int WORDS = 6;
  localparam int WAKE  = 75;
  localparam int NBYTE = 5 + 2 * WORDS + 1;

  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  logic        spi_req, spi_frame, spi_busy;
  logic [7:0]  spi_tx, spi_rx;
  logic [15:0] sram_addr, sram_dq_o, sram_dq_i, cpu_pc, rom_data, instr;
  logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n, cpu_rst, go;

  flash_boot_loader #(.WORDS(WORDS), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst(rst), .spi_req(spi_req), .spi_tx(spi_tx), .spi_frame(spi_frame),
    .spi_busy(spi_busy), .spi_rx(spi_rx), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .cpu_pc(cpu_pc), .rom_data(rom_data),
    .instr(instr), .cpu_rst(cpu_rst), .go(go));

  int checks = 0, failures = 0;
  int seed = 1;
  int cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] img(int s, int k);
    return 8'((s * 37 + k * 29 + 5) & 255);
  endfunction

  // byte engine model: busy rises the cycle after a request, lasts 4 cycles
  int nb, cnt, req_err;
  logic [7:0] tx_log [0:31];
  logic       fr_log [0:31];
  int         req_cyc [0:31];
  int         end_cyc [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst) begin
      spi_busy <= 0; spi_rx <= 8'hFF; cnt <= 0; nb <= 0; req_err <= 0;
    end else begin
      if (spi_busy && spi_req) req_err <= req_err + 1;
      if (spi_busy) begin
        if (cnt == 0) begin
          spi_busy <= 0;
          if (nb - 1 < 32) end_cyc[nb-1] <= cyc;
          if (nb - 1 >= 5 && nb - 1 < 5 + 2 * WORDS) spi_rx <= img(seed, nb - 6);
          else spi_rx <= 8'hFF;
        end else cnt <= cnt - 1;
      end else if (spi_req) begin
        spi_busy <= 1; cnt <= 3;
        if (nb < 32) begin
          tx_log[nb] <= spi_tx; fr_log[nb] <= spi_frame; req_cyc[nb] <= cyc;
        end
        nb <= nb + 1;
      end
    end
  end

  // SRAM and output monitor, sampled on the falling edge
  logic [15:0] mem [0:15];
  int wr_count, addr_err, strobe_err, crst_err, instr_err, pulse_err, go_cyc, crst_fall;
  bit prev_req, prev_crst;
  always @(negedge clk) begin
    if (rst) begin
      wr_count = 0; addr_err = 0; strobe_err = 0; crst_err = 0; instr_err = 0;
      pulse_err = 0; go_cyc = -1; crst_fall = -1; prev_req = 0; prev_crst = 1;
      for (int i = 0; i < 16; i++) mem[i] = 16'hDEAD;
    end else begin
      if (sram_ce_n !== 1'b0) strobe_err++;
      if (sram_we_n === 1'b0) begin
        if (!(sram_oe_n === 1'b1 && sram_dq_oe === 1'b1)) strobe_err++;
        if (sram_addr != 16'(wr_count)) addr_err++;
        mem[sram_addr[3:0]] = sram_dq_o;
        wr_count++;
      end else if (!(sram_oe_n === 1'b0 && sram_dq_oe === 1'b0)) strobe_err++;
      if (!go && !cpu_rst) crst_err++;
      if (!go && instr !== rom_data) instr_err++;
      if (go && go_cyc < 0) go_cyc = cyc;
      if (prev_crst && !cpu_rst) crst_fall = cyc;
      if (prev_req && spi_req) pulse_err++;
      prev_req = spi_req; prev_crst = cpu_rst;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(go == 0 && spi_req == 0, "R10 go/req", {go, spi_req}, 0);
    chk(cpu_rst == 1 && sram_we_n == 1 && sram_oe_n == 0 && sram_dq_oe == 0,
        "R10 strobes", {cpu_rst, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1100);
  endtask

  task automatic test_load(input int s);
    int t;
    seed = s;
    rom_data = 16'hC0DE + 16'(s);
    cpu_pc = 16'h0077;
    sram_dq_i = 16'h0000;
    @(negedge clk);
    rst = 0;
    t = 0;
    while (!go && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(go == 1, "R5 go reached", go, 1);
    chk(tx_log[0] == 8'hAB && fr_log[0] == 0, "R1 wake byte", {fr_log[0], tx_log[0]}, 9'h0AB);
    chk(req_cyc[1] - end_cyc[0] >= WAKE, "R2 wake gap", req_cyc[1] - end_cyc[0], WAKE);
    chk({tx_log[1], tx_log[2], tx_log[3], tx_log[4]} == 32'h03010000, "R3 read header",
        {tx_log[1], tx_log[2], tx_log[3], tx_log[4]}, 32'h03010000);
    begin
      int bad = 0;
      for (int i = 1; i < 5 + 2 * WORDS; i++) if (fr_log[i] !== 1'b1) bad++;
      chk(bad == 0, "R3 frame held", bad, 0);
    end
    chk(nb == NBYTE, "R5 byte count", nb, NBYTE);
    chk(tx_log[NBYTE-1] == 8'hB9 && fr_log[NBYTE-1] == 0, "R5 sleep byte",
        {fr_log[NBYTE-1], tx_log[NBYTE-1]}, 9'h0B9);
    chk(go_cyc > end_cyc[NBYTE-1], "R5 go after sleep", go_cyc, end_cyc[NBYTE-1]);
    chk(wr_count == WORDS && addr_err == 0, "R4 write count/order", {wr_count, addr_err}, WORDS);
    for (int i = 0; i < WORDS; i++)
      chk(mem[i] == {img(s, 2 * i), img(s, 2 * i + 1)}, "R4 word", mem[i],
          {img(s, 2 * i), img(s, 2 * i + 1)});
    chk(strobe_err == 0, "R6 strobes", strobe_err, 0);
    chk(crst_err == 0, "R7 cpu held", crst_err, 0);
    chk(crst_fall == go_cyc + 1, "R7 reset release", crst_fall, go_cyc + 1);
    chk(req_err == 0 && pulse_err == 0, "R9 handshake", {req_err, pulse_err}, 0);
    chk(instr_err == 0, "R8 rom fetch", instr_err, 0);
  endtask

  task automatic test_fetch();
    cpu_pc = 16'h0003; sram_dq_i = 16'h5A5A; rom_data = 16'h1111;
    @(negedge clk);
    chk(sram_addr == 16'h0003 && instr == 16'h5A5A, "R8 sram fetch", {sram_addr, instr}, 32'h00035A5A);
    cpu_pc = 16'h00F0; sram_dq_i = 16'hA5C3;
    @(negedge clk);
    chk(sram_addr == 16'h00F0 && instr == 16'hA5C3, "R8 pc follow", {sram_addr, instr}, 32'h00F0A5C3);
  endtask

  task automatic test_sticky();
    int n0, w0;
    n0 = nb; w0 = wr_count;
    repeat (60) begin
      @(negedge clk);
      rom_data = rom_data + 16'h0101; cpu_pc = cpu_pc + 1;
    end
    chk(go == 1 && cpu_rst == 0, "R7 go sticky", {go, cpu_rst}, 2'b10);
    chk(nb == n0 && wr_count == w0, "R11 quiet after go", {nb, wr_count}, {n0, w0});
  endtask

  initial begin
    rom_data = 0; cpu_pc = 0; sram_dq_i = 0;
    test_reset();
    test_load(1);
    test_fetch();
    test_sticky();
    test_reset();
    test_load(9);
    test_fetch();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule